// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block sits beside a small 8-bit processor core and turns five interrupt request lines into one 16-bit service address. One line is a non-maskable trap. Three lines have fixed addresses wired into the block. The fifth is a general request that has no address of its own: the block acknowledges it on an active-low strobe, and the requesting device then places a one-byte restart opcode on the data bus. The block decodes that byte into an address. The core raises a strobe at every instruction boundary, and the block only makes a decision on a cycle where that strobe is high.

A global enable gates every source except the trap. Software controls it with separate set and clear strobes. Each of the three fixed-address lines also has its own mask bit in a mask register. When any maskable source is taken, the global enable is cleared, and only a later set strobe turns it back on. The highest fixed-address line captures rising edges in a latch, so a short pulse stays pending until that line is serviced or until software clears the latch. The trap is also taken on a rising edge, but it is dropped if the line falls before it is serviced. The two lower fixed lines and the general request are level-sensitive.

The opcode byte arrives on a valid/ready port. `bus_ready_o` is high only while the acknowledge strobe is low, and a byte is taken on a clock edge where valid and ready are both high. The vector leaves on a valid/ready port. Once `vec_valid_o` rises, it stays high and `vec_addr_o` stays stable until the consumer raises `vec_ready_i`. No new decision is made until that transfer completes.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `ack_n_o` is 1, `vec_valid_o` is 0, `bus_ready_o` is 0 and `ien_o` is 0. All three mask bits are set, which means masked.
- R2: When more than one request is eligible at a boundary, the winner follows this order, highest first: trap, edge line, middle line, low line, general request.
- R3: The fixed addresses are 0x0024 for the trap, 0x003C for the edge line, 0x0034 for the middle line and 0x002C for the low line.
- R4: A pending trap is taken whatever the global enable and the mask bits hold. Taking a trap leaves `ien_o` unchanged.
- R5: The edge, middle and low lines are taken only when `ien_o` is 1 and their mask bit is 0. The mask bits are written through `mask_data_i` on a cycle where `mask_wr_i` is high: bit 2 masks the edge line, bit 1 the middle line and bit 0 the low line. The general request needs only `ien_o` to be 1.
- R6: A rising edge on `irq_edge_i` stays pending, even after the line falls and even while the line is masked, until the line is serviced. Writing the mask register with `mask_data_i[3]`=1 discards the pending edge.
- R7: A request is taken only on a cycle where `boundary_i` is high and no earlier request is still in progress. With `boundary_i` low, no output moves.
- R8: When the general request wins, `ack_n_o` goes low and `bus_ready_o` goes high. Both stay that way until a byte is accepted. A byte of the form 11nnn111 produces the address n*8, where n is bits 5:3 (range 0x0000 to 0x0038).
- R9: An accepted byte that does not match 11nnn111 raises `bad_op_o` for one cycle, produces no vector and releases the acknowledge.
- R10: Taking any maskable source clears `ien_o`. A clear strobe takes precedence over a set strobe given in the same cycle.
- R11: The trap is taken only after a rising edge and only while the line is still high. A trap held high is serviced once. A trap pulse that falls before a boundary is lost.
- R12: While `vec_valid_o` is 1 and `vec_ready_i` is 0, `vec_valid_o` and `vec_addr_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable trap request |
| irq_edge_i | input | 1 | Edge-captured fixed-address line (highest of the maskable sources) |
| irq_mid_i | input | 1 | Level fixed-address line, middle priority |
| irq_low_i | input | 1 | Level fixed-address line, lowest of the fixed lines |
| ext_req_i | input | 1 | General level request; its address comes from the device |
| ien_set_i | input | 1 | Strobe that sets the global enable |
| ien_clr_i | input | 1 | Strobe that clears the global enable |
| ien_o | output | 1 | Current global enable |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 4 | Bits 2..0 are the masks (edge, middle, low); bit 3 discards the pending edge |
| boundary_i | input | 1 | Instruction-boundary strobe |
| bus_valid_i | input | 1 | Opcode byte valid |
| bus_ready_o | output | 1 | Opcode byte ready, high while acknowledging |
| bus_data_i | input | 8 | Opcode byte |
| ack_n_o | output | 1 | Acknowledge for the general request, active low |
| bad_op_o | output | 1 | One-cycle pulse on a malformed opcode |
| vec_valid_o | output | 1 | Service address valid |
| vec_ready_i | input | 1 | Consumer accepts the service address |
| vec_addr_o | output | 16 | Service address |

## Verification
The hardest case to reach from the ports is a one-cycle pulse on the edge line that must still be pending several boundaries later. The bench arranges this by pulsing the line while the middle, low and general requests are also held, then also while the line is masked, and by discarding the pending edge through a mask write. A second hard case is a trap that falls before any boundary, which must leave nothing behind. The general request path is driven through the full acknowledge and byte transfer with both valid and malformed opcodes. A stalled consumer is used to hold a vector in place.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK,
    ST_OUT
  } ivu_state_e;

  localparam int NUM_SRC  = 5;
  localparam int SRC_TRAP = 0;
  localparam int SRC_EDGE = 1;
  localparam int SRC_MID  = 2;
  localparam int SRC_LOW  = 3;
  localparam int SRC_EXT  = 4;

  // Fixed address = (restart number * 2) * 4; the doubled restart numbers are 9, 15, 13 and 11.
  function automatic logic [15:0] fixed_vec(input int unsigned src);
    logic [15:0] twice;
    case (src)
      SRC_TRAP: twice = 16'd9;
      SRC_EDGE: twice = 16'd15;
      SRC_MID:  twice = 16'd13;
      default:  twice = 16'd11;
    endcase
    return twice << 2;
  endfunction

endpackage

// File: rtl/ivu_edge_cap.sv
module ivu_edge_cap #(
  parameter bit HELD_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;
  logic drop;

  // With HELD_QUAL set, the pending request is dropped as soon as the line falls.
  assign drop = clr_i | (HELD_QUAL & ~sig_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
      pend_q <= (pend_q & ~drop) | (sig_i & ~prev_q);
    end
  end

  assign pend_o = HELD_QUAL ? (pend_q & sig_i) : pend_q;

  AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_i && !prev_q) |=> pend_q) else $error("edge lost"); // R6
endmodule

// File: rtl/ivu_prio.sv
module ivu_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N:0] seen;

  // Index 0 has the highest priority; each grant is blocked by any request below its index.
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant_o[g]  = req_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | req_i[g];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/ivu_op_decode.sv
module ivu_op_decode #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [DATA_W-1:0] op_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int NUM_LSB = 3;

  assign ok_o   = (op_i[DATA_W-1 -: 2] == 2'b11) && (op_i[NUM_LSB-1:0] == '1);
  assign addr_o = ADDR_W'({op_i[NUM_LSB +: 3], 3'b000});
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import ivu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              irq_edge_i,
  input  logic              irq_mid_i,
  input  logic              irq_low_i,
  input  logic              ext_req_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  output logic              ien_o,
  input  logic              mask_wr_i,
  input  logic [3:0]        mask_data_i,
  input  logic              boundary_i,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              ack_n_o,
  output logic              bad_op_o,
  output logic              vec_valid_o,
  input  logic              vec_ready_i,
  output logic [ADDR_W-1:0] vec_addr_o
);
  localparam int NMASK = 3;

  ivu_state_e         state_q;
  logic [NMASK-1:0]   mask_q;
  logic               ien_q;
  logic [ADDR_W-1:0]  vec_q;
  logic               bad_q;
  logic               trap_pend, edge_pend;
  logic [NUM_SRC-1:0] req, grant;
  logic               any_req, take, take_mask;
  logic               op_ok;
  logic [ADDR_W-1:0]  op_addr;
  logic [ADDR_W-1:0]  fix_addr;
  logic               bus_fire;

  ivu_edge_cap #(.HELD_QUAL(1'b1)) u_trap_cap (
    .clk(clk), .rst_n(rst_n), .sig_i(trap_i),
    .clr_i(take & grant[SRC_TRAP]), .pend_o(trap_pend)
  );

  ivu_edge_cap #(.HELD_QUAL(1'b0)) u_edge_cap (
    .clk(clk), .rst_n(rst_n), .sig_i(irq_edge_i),
    .clr_i((take & grant[SRC_EDGE]) | (mask_wr_i & mask_data_i[3])),
    .pend_o(edge_pend)
  );

  assign req[SRC_TRAP] = trap_pend;
  assign req[SRC_EDGE] = ien_q & ~mask_q[2] & edge_pend;
  assign req[SRC_MID]  = ien_q & ~mask_q[1] & irq_mid_i;
  assign req[SRC_LOW]  = ien_q & ~mask_q[0] & irq_low_i;
  assign req[SRC_EXT]  = ien_q & ext_req_i;

  ivu_prio #(.N(NUM_SRC)) u_prio (
    .req_i(req), .grant_o(grant), .any_o(any_req)
  );

  ivu_op_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .op_i(bus_data_i), .ok_o(op_ok), .addr_o(op_addr)
  );

  assign take      = (state_q == ST_IDLE) && boundary_i && any_req;
  assign take_mask = take && !grant[SRC_TRAP];
  assign bus_fire  = (state_q == ST_ACK) && bus_valid_i;

  always_comb begin
    fix_addr = '0;
    for (int s = 0; s < SRC_EXT; s++) begin
      if (grant[s]) fix_addr = ADDR_W'(fixed_vec(s));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      if (take_mask || ien_clr_i) ien_q <= 1'b0;
      else if (ien_set_i)         ien_q <= 1'b1;
      if (mask_wr_i) mask_q <= mask_data_i[NMASK-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (take) begin
          if (grant[SRC_EXT]) begin
            state_q <= ST_ACK;
          end else begin
            state_q <= ST_OUT;
            vec_q   <= fix_addr;
          end
        end
        ST_ACK: if (bus_fire) begin
          if (op_ok) begin
            state_q <= ST_OUT;
            vec_q   <= op_addr;
          end else begin
            state_q <= ST_IDLE;
            bad_q   <= 1'b1;
          end
        end
        ST_OUT: if (vec_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ien_o       = ien_q;
  assign ack_n_o     = (state_q != ST_ACK);
  assign bus_ready_o = (state_q == ST_ACK);
  assign vec_valid_o = (state_q == ST_OUT);
  assign vec_addr_o  = vec_q;
  assign bad_op_o    = bad_q;

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_addr_o))) else $error("vector moved"); // R12
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ack_n_o && vec_valid_o)) else $error("ack with vector"); // R8
  AST_BAD_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op_o |-> ($past(!ack_n_o) && !vec_valid_o)) else $error("stray bad op"); // R9
  AST_IEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    take_mask |=> !ien_o) else $error("enable kept"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !boundary_i) |=> (!vec_valid_o && ack_n_o)) else $error("took off boundary"); // R7
  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && boundary_i && trap_pend) |=> (vec_valid_o && vec_addr_o == 16'h0024)) else $error("trap lost"); // R4
  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (vec_addr_o[ADDR_W-1:6] == '0 && vec_addr_o[1:0] == 2'b00)) else $error("bad vector"); // R3
endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_i = 0, irq_edge_i = 0, irq_mid_i = 0, irq_low_i = 0, ext_req_i = 0;
  logic ien_set_i = 0, ien_clr_i = 0, mask_wr_i = 0, boundary_i = 0;
  logic [3:0] mask_data_i = 4'h0;
  logic bus_valid_i = 0, vec_ready_i = 1;
  logic [7:0] bus_data_i = 8'h00;
  logic ien_o, bus_ready_o, ack_n_o, bad_op_o, vec_valid_o;
  logic [15:0] vec_addr_o;

  int checks = 0;
  int fails = 0;
  logic [16:0] exp_q[$];   // bit 16 set marks an expected malformed-opcode pulse
  localparam logic [16:0] BAD_MARK = 17'h10000;

  always #4 clk = ~clk;    // 125 MHz

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .irq_edge_i(irq_edge_i),
    .irq_mid_i(irq_mid_i), .irq_low_i(irq_low_i), .ext_req_i(ext_req_i),
    .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .ien_o(ien_o),
    .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i), .boundary_i(boundary_i),
    .bus_valid_i(bus_valid_i), .bus_ready_o(bus_ready_o), .bus_data_i(bus_data_i),
    .ack_n_o(ack_n_o), .bad_op_o(bad_op_o), .vec_valid_o(vec_valid_o),
    .vec_ready_i(vec_ready_i), .vec_addr_o(vec_addr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every vector handshake and every malformed-opcode pulse.
  always @(negedge clk) begin
    if (rst_n && ((vec_valid_o && vec_ready_i) || bad_op_o)) begin
      logic [16:0] got;
      got = bad_op_o ? BAD_MARK : {1'b0, vec_addr_o};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2/R7: unexpected output actual %h expected none", got);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        if (got !== e) begin
          fails++;
          $display("FAIL R2/R3/R8: actual %h expected %h", got, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bnd();
    @(posedge clk); #1 boundary_i = 1'b1;
    @(posedge clk); #1 boundary_i = 1'b0;
    tick(3);
  endtask

  task automatic ien_on();
    @(posedge clk); #1 ien_set_i = 1'b1;
    @(posedge clk); #1 ien_set_i = 1'b0;
  endtask

  task automatic mask_wr(input logic [3:0] d);
    @(posedge clk); #1 mask_wr_i = 1'b1; mask_data_i = d;
    @(posedge clk); #1 mask_wr_i = 1'b0;
  endtask

  task automatic edge_pulse();
    @(posedge clk); #1 irq_edge_i = 1'b1;
    @(posedge clk); #1 irq_edge_i = 1'b0;
  endtask

  // Driver for the general request path: pushes its expectation, then runs the byte transfer.
  task automatic ext_run(input logic [7:0] op, input logic [16:0] e, input string req);
    ien_on();
    ext_req_i = 1'b1;
    exp_q.push_back(e);
    @(posedge clk); #1 boundary_i = 1'b1;
    @(posedge clk); #1 boundary_i = 1'b0; ext_req_i = 1'b0;
    tick(2);
    @(negedge clk);
    chk({req, " ack low"}, ack_n_o, 1'b0);
    chk({req, " bus ready"}, bus_ready_o, 1'b1);
    @(posedge clk); #1 bus_valid_i = 1'b1; bus_data_i = op;
    @(posedge clk); #1 bus_valid_i = 1'b0;
    tick(3);
    chk({req, " ack released"}, ack_n_o, 1'b1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 ack", ack_n_o, 1'b1);
    chk("R1 valid", vec_valid_o, 1'b0);
    chk("R1 ready", bus_ready_o, 1'b0);
    chk("R1 ien", ien_o, 1'b0);

    // R4 trap ignores disabled/masked state; R11 held trap serviced once
    trap_i = 1'b1;
    tick(2);
    exp_q.push_back(17'h0024);
    bnd();
    chk("R4 ien untouched", ien_o, 1'b0);
    bnd();                    // still high: must not repeat
    trap_i = 1'b0;
    tick(1);
    chk("R11 single service", exp_q.size(), 0);
    // R11 pulse that falls before the boundary is lost
    trap_i = 1'b1; tick(2); trap_i = 1'b0; tick(2);
    bnd();

    // R5 gating by enable and mask (reset masks all set)
    irq_low_i = 1'b1;
    bnd();
    ien_on();
    chk("R10 set strobe", ien_o, 1'b1);
    bnd();                    // masked: nothing
    mask_wr(4'b0000);
    exp_q.push_back(17'h002C);
    bnd();
    chk("R10 cleared on take", ien_o, 1'b0);
    // R10 clear beats set
    @(posedge clk); #1 ien_set_i = 1'b1; ien_clr_i = 1'b1;
    @(posedge clk); #1 ien_set_i = 1'b0; ien_clr_i = 1'b0;
    chk("R10 clear wins", ien_o, 1'b0);

    // R7 no boundary, no response
    ien_on();
    tick(10);
    chk("R7 quiet valid", vec_valid_o, 1'b0);
    chk("R7 quiet ack", ack_n_o, 1'b1);

    // R2 ordering with R6 one-cycle edge pulse
    irq_mid_i = 1'b1; ext_req_i = 1'b1;
    edge_pulse();
    tick(2);
    exp_q.push_back(17'h003C);
    bnd();
    ien_on();
    exp_q.push_back(17'h0034);
    bnd();
    irq_mid_i = 1'b0;
    ien_on();
    exp_q.push_back(17'h002C);
    bnd();
    irq_low_i = 1'b0; ext_req_i = 1'b0;
    // R2 trap beats a maskable level; trap keeps ien
    ien_on();
    irq_mid_i = 1'b1; trap_i = 1'b1;
    tick(2);
    exp_q.push_back(17'h0024);
    bnd();
    chk("R4 ien kept after trap", ien_o, 1'b1);
    trap_i = 1'b0;
    exp_q.push_back(17'h0034);
    bnd();
    irq_mid_i = 1'b0;

    // R6 discard pending edge
    edge_pulse();
    mask_wr(4'b1000);
    ien_on();
    bnd();
    chk("R6 discarded", exp_q.size(), 0);
    // R6 masked edge stays pending
    mask_wr(4'b0100);
    edge_pulse();
    bnd();
    mask_wr(4'b0000);
    exp_q.push_back(17'h003C);
    bnd();

    // R8 device opcodes, R9 malformed
    ext_run(8'hEF, 17'h0028, "R8 n5");
    ext_run(8'hC7, 17'h0000, "R8 n0");
    ext_run(8'hFF, 17'h0038, "R8 n7");
    ext_run(8'hC6, BAD_MARK, "R9 bad");
    chk("R9 no vector", vec_valid_o, 1'b0);

    // R12 stalled consumer
    vec_ready_i = 1'b0;
    trap_i = 1'b1;
    tick(2);
    @(posedge clk); #1 boundary_i = 1'b1;
    @(posedge clk); #1 boundary_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R12 valid held", vec_valid_o, 1'b1);
      chk("R12 addr held", vec_addr_o, 16'h0024);
    end
    exp_q.push_back(17'h0024);
    @(posedge clk); #1 vec_ready_i = 1'b1;
    trap_i = 1'b0;
    tick(4);

    chk("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule